// File: doc/BRIEF.md
# Chainable Serial Loader for a 12-bit Converter Code

This block takes a converter code from a three-wire serial link and holds it in a parallel code register. The three wires are a serial clock, a serial data input and a select line that also acts as the load command. The pins come from outside the chip's clock domain. Each pin passes through a two-flop synchronizer, and the edges are then found in the system clock domain. While the select line is low, each rising edge of the serial clock shifts one data bit into a 12-bit shift register, most significant bit first. When the select line rises, the shift register contents move into the code register, and a one-cycle strobe tells the converter interface that a new code is present.

There is no bit counter and no word framing. The code that gets loaded is whatever sits in the shift register when the select line rises. The top stage of the shift register drives a serial output. Several blocks can therefore be chained: each one's serial output feeds the next one's data input, and all of them share the clock and select lines. One long transfer fills the whole chain, and a single rising edge of the select line updates every block at once.

Top module: `serial_dac_loader`

## Requirements
- R1: Reset clears the code register and the shift register to 0. After reset, `dac_code_o` is 0, `sdout_o` is 0 and `dac_load_o` is 0.
- R2: While `csld_i` is low, each rising edge of `sclk_i` shifts `sdin_i` into bit 0 of the shift register and moves the other bits up one place. Falling edges do nothing. After 12 edges, the first bit sent sits in bit 11 of the loaded code.
- R3: While `csld_i` is high, edges on `sclk_i` are ignored: `sdout_o` and the shift register contents do not change.
- R4: A low-to-high change of `csld_i` copies the shift register into `dac_code_o`. At no other time does `dac_code_o` change.
- R5: `sdout_o` is bit 11 of the shift register. When it is sampled just before each accepted rising edge of a new 12-bit transfer, it shows the previously held word, most significant bit first.
- R6: Without framing, the shift register keeps only the last 12 bits clocked in during a low period of `csld_i`. If fewer than 12 bits arrive, the loaded word is the older contents shifted up by that many places, with the new bits in the low positions.
- R7: A rising edge of `sclk_i` that the synchronizers see in the same cycle as `csld_i` falling counts as a valid shift.
- R8: `dac_load_o` is high for exactly one system clock cycle for each rising edge of `csld_i`. This holds even when the loaded code equals the old one.
- R9: When two blocks are chained (`sdout_o` to `sdin_i`, with shared clock and select lines), a 24-bit transfer leaves the first 12 bits sent in the far block and the last 12 bits in the near block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk_i | input | 1 | Serial clock pin, asynchronous |
| sdin_i | input | 1 | Serial data pin, asynchronous |
| csld_i | input | 1 | Select/load pin: low enables shifting, a rising edge loads |
| sdout_o | output | 1 | Top bit of the shift register, for chaining |
| dac_code_o | output | 12 | Code register feeding the converter |
| dac_load_o | output | 1 | One-cycle strobe when the code register loads |

## Verification
The bench drives a serial clock edge that arrives in the same synchronized cycle as the select line falling. A design that treated this edge as part of the inactive phase would drop the leading bit, and the loaded code would come out one bit short. It toggles the serial clock while select is high and then sends a select pulse with no clock edges. A design that kept shifting while deselected would change `sdout_o`, and a load that was gated on a changed code would leave out the strobe. It also sends over-length and short transfers and runs a two-block chain, where a bit counter or a serial output that was late by one stage would place the words wrongly. In every transfer, the bits that appear on `sdout_o` are compared with the word held before.

// File: rtl/sdl_pkg.sv
package sdl_pkg;

    // Synchronized view of the three serial pins.
    typedef struct packed {
        logic csld;
        logic sclk;
        logic sdin;
    } pins_t;

    localparam int PINS_W = $bits(pins_t);

    // Deselected, clock low: the idle state of the link.
    localparam pins_t PINS_IDLE = '{csld: 1'b1, sclk: 1'b0, sdin: 1'b0};

endpackage

// File: rtl/sdl_sync.sv
module sdl_sync #(
    parameter int          W       = 3,
    parameter int          STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);

    logic [W-1:0] stage_q [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        logic [W-1:0] stage_d;
        if (g == 0) begin : g_first
            assign stage_d = d_i;
        end else begin : g_next
            assign stage_d = stage_q[g-1];
        end
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q[g] <= RST_VAL;
            else        stage_q[g] <= stage_d;
        end
    end

    assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/sdl_edge.sv
module sdl_edge
    import sdl_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  pins_t pins_i,
    output logic  shift_en_o,
    output logic  load_en_o,
    output logic  din_o
);

    typedef struct packed {
        logic sclk;
        logic csld;
    } prev_t;

    prev_t prev_d, prev_q;

    always_comb begin
        prev_d      = prev_q;
        prev_d.sclk = pins_i.sclk;
        prev_d.csld = pins_i.csld;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '{sclk: PINS_IDLE.sclk, csld: PINS_IDLE.csld};
        else        prev_q <= prev_d;
    end

    // A rising clock edge counts if select is low in the same cycle, even
    // when select was high one cycle earlier.
    assign shift_en_o = pins_i.sclk && !prev_q.sclk && !pins_i.csld;
    assign load_en_o  = pins_i.csld && !prev_q.csld;
    assign din_o      = pins_i.sdin;

    // R3
    shift_load_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({shift_en_o, load_en_o}));

endmodule

// File: rtl/sdl_core.sv
module sdl_core #(
    parameter int CODE_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shift_en_i,
    input  logic              load_en_i,
    input  logic              din_i,
    output logic [CODE_W-1:0] code_o,
    output logic              sout_o,
    output logic              load_o
);

    typedef struct packed {
        logic [CODE_W-1:0] sh;
        logic [CODE_W-1:0] dac;
        logic              stb;
    } core_t;

    core_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.stb = 1'b0;
        if (shift_en_i) begin
            st_d.sh = {st_q.sh[CODE_W-2:0], din_i};
        end
        if (load_en_i) begin
            st_d.dac = st_q.sh;
            st_d.stb = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign code_o = st_q.dac;
    assign sout_o = st_q.sh[CODE_W-1];
    assign load_o = st_q.stb;

    // R2
    shift_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        shift_en_i |=> st_q.sh == {$past(st_q.sh[CODE_W-2:0]), $past(din_i)});

    // R3
    shift_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !shift_en_i |=> $stable(st_q.sh));

    // R4
    load_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_en_i |=> (code_o == $past(st_q.sh)) && load_o);

    // R4
    code_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !load_en_i |=> $stable(code_o));

    // R8
    strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_o |=> !load_o);

endmodule

// File: rtl/serial_dac_loader.sv
module serial_dac_loader
    import sdl_pkg::*;
#(
    parameter int CODE_W      = 12,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_i,
    input  logic              sdin_i,
    input  logic              csld_i,
    output logic              sdout_o,
    output logic [CODE_W-1:0] dac_code_o,
    output logic              dac_load_o
);

    pins_t              raw_pins;
    logic [PINS_W-1:0]  sync_bits;
    pins_t              sync_pins;
    logic               shift_en;
    logic               load_en;
    logic               din;

    assign raw_pins  = '{csld: csld_i, sclk: sclk_i, sdin: sdin_i};
    assign sync_pins = pins_t'(sync_bits);

    sdl_sync #(
        .W       (PINS_W),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (PINS_IDLE)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (raw_pins),
        .q_o   (sync_bits)
    );

    sdl_edge u_edge (
        .clk        (clk),
        .rst_n      (rst_n),
        .pins_i     (sync_pins),
        .shift_en_o (shift_en),
        .load_en_o  (load_en),
        .din_o      (din)
    );

    sdl_core #(
        .CODE_W (CODE_W)
    ) u_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .shift_en_i (shift_en),
        .load_en_i  (load_en),
        .din_i      (din),
        .code_o     (dac_code_o),
        .sout_o     (sdout_o),
        .load_o     (dac_load_o)
    );

endmodule

// File: tb/serial_dac_loader_tb.sv
module serial_dac_loader_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sclk = 1'b0;
    logic        sdin = 1'b0;
    logic        csld = 1'b1;
    logic        sdout, sdout_b;
    logic [11:0] code, code_b;
    logic        load, load_b;

    int tests = 0;
    int fails = 0;
    int strobes = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    serial_dac_loader u_dut (
        .clk (clk), .rst_n (rst_n), .sclk_i (sclk), .sdin_i (sdin),
        .csld_i (csld), .sdout_o (sdout), .dac_code_o (code), .dac_load_o (load)
    );

    // Downstream block of a two-deep chain (R9).
    serial_dac_loader u_dut_b (
        .clk (clk), .rst_n (rst_n), .sclk_i (sclk), .sdin_i (sdout),
        .csld_i (csld), .sdout_o (sdout_b), .dac_code_o (code_b), .dac_load_o (load_b)
    );

    always @(negedge clk) if (rst_n && load) strobes++;

    localparam logic [11:0] VEC [8] = '{12'h000, 12'hFFF, 12'hA5A, 12'h5A5,
                                        12'h800, 12'h001, 12'h3C7, 12'hBEE};

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Sends n bits (bits[n-1] first); seen collects sdout before each rise.
    task automatic send(input logic [31:0] bits, input int n, output logic [31:0] seen);
        seen = '0;
        csld = 1'b0; idle(4);
        for (int i = n - 1; i >= 0; i--) begin
            sclk = 1'b0; sdin = bits[i]; idle(4);
            seen = {seen[30:0], sdout};
            sclk = 1'b1; idle(4);
        end
        sclk = 1'b0; idle(4);
        csld = 1'b1; idle(4);
    endtask

    initial begin
        logic [31:0] seen;
        logic [11:0] prev;
        int          s0;

        idle(3);
        // R1
        chk("R1 code", code, 0);
        chk("R1 sdout", sdout, 0);
        chk("R1 strobe", load, 0);
        rst_n = 1'b1; idle(4);
        chk("R1 code after release", code, 0);

        // Vector table: R2, R4, R5, R8
        prev = 12'h000;
        for (int v = 0; v < 8; v++) begin
            s0 = strobes;
            send({20'h0, VEC[v]}, 12, seen);
            chk("R2/R4 loaded code", code, VEC[v]);
            chk("R8 one strobe", strobes - s0, 1);
            chk("R5 serial out is previous word", seen[11:0], prev);
            prev = VEC[v];
        end

        // R3: clock toggles while deselected are ignored
        for (int i = 0; i < 5; i++) begin
            sdin = ~sdin; sclk = 1'b1; idle(4); sclk = 1'b0; idle(4);
        end
        chk("R3 sdout unchanged", sdout, prev[11]);
        chk("R3 code unchanged", code, prev);
        // R3/R8: select pulse with no clocks reloads the same word
        s0 = strobes;
        csld = 1'b0; idle(4);
        chk("R4 no load on select fall", code, prev);
        csld = 1'b1; idle(4);
        chk("R3 shift reg untouched", code, prev);
        chk("R8 strobe on same code", strobes - s0, 1);

        // R6: 16 bits keep the last 12; then 4 bits shift the old word up
        send(32'h1234, 16, seen);
        chk("R6 over-length keeps last 12", code, 12'h234);
        send(32'hF, 4, seen);
        chk("R6 short transfer", code, 12'h34F);

        // R7: clock rise seen together with select fall
        begin
            logic [11:0] w = 12'hC3A;
            sclk = 1'b0; csld = 1'b1; sdin = w[11]; idle(4);
            csld = 1'b0; sclk = 1'b1; idle(4);
            for (int i = 10; i >= 0; i--) begin
                sclk = 1'b0; sdin = w[i]; idle(4);
                sclk = 1'b1; idle(4);
            end
            sclk = 1'b0; idle(4);
            csld = 1'b1; idle(4);
            chk("R7 coincident edge shifts", code, w);
        end

        // R9: chain of two, 24 bits
        send({8'h0, 12'h9E1, 12'h47B}, 24, seen);
        chk("R9 far block", code_b, 12'h9E1);
        chk("R9 near block", code, 12'h47B);

        // R1: reset in mid-run
        rst_n = 1'b0; idle(2);
        chk("R1 reset clears code", code, 0);
        chk("R1 reset clears sdout", sdout, 0);
        rst_n = 1'b1; idle(2);

        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            tests++; fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule